// File: doc/BRIEF.md
# Interrupt Pin Delivery Controller

This block watches a bank of interrupt input lines. Using each pin's trigger mode and mask, it decides when the pin needs a delivery request sent to a downstream interrupt fabric. Each pin has three pieces of state. The first is a request bit. The second is a "sent" flag, used by edge-triggered pins. The third is a "remote pending" flag, used by level-triggered pins, which holds the pin off until the fabric reports completion. Pins that need service go through a fixed-priority arbiter. The arbiter presents one request at a time on a valid/ready handshake, together with the pin's vector, destination and delivery-mode fields.

An assertion that adds no new delivery is reported as coalesced, through a one-cycle pulse on that pin's bit. Two inputs release a level pin that is being held off: a completion-clear input and a table-entry-rewrite strobe. The rewrite strobe also marks the moment when a newly unmasked pin with a latched request is retried.

Top module: `irq_pin_deliver`

## Requirements
- R1: A level pin whose line is sampled low has its request bit cleared, so a level pulse that ends while the pin is masked never produces a request, even after the pin is unmasked. An edge pin's request bit is cleared by a low line only after that pin has been sent.
- R2: Only a 0→1 change between two consecutive samples counts as an assertion; a line that stays high produces no further request. An edge assertion that finds the pin's request bit set and not yet sent is coalesced: `coalesced` bit i is 1 in the cycle after that sample, and no extra request is made.
- R3: A level assertion that arrives while the pin's remote-pending flag is set is coalesced (`coalesced` bit i pulses) and produces no request.
- R4: A masked pin never produces a request, and its request bit stays latched while the mask is set.
- R5: Accepting an edge pin's request sets its sent flag, so the pin is not requested again. A later 0→1 assertion clears the flag and leads to a new request.
- R6: Accepting a level pin's request (`reqLevel`=1) sets its remote-pending flag. A pulse on `eoiClrStb` with `eoiClrIdx` equal to the pin clears the flag, and the pin is then requested again if its line is still high.
- R7: A pulse on `entryWrStb` with `entryWrIdx` equal to the pin clears its remote-pending flag. A level pin whose request bit is set is then serviced again, and a pin unmasked at that point with a latched request is requested.
- R8: When several pins need service at once, the lowest-numbered pin is presented first. Only one request is outstanding at a time.
- R9: While `reqValid`=1 and `reqReady`=0, `reqPin`, `reqVector`, `reqDest`, `reqDelMode` and `reqLevel` hold steady. The field values are the pin's table fields, captured when the request is loaded.
- R10: A request appears two clock edges after the sampled assertion. `reqValid` is 0 in the cycle after an accepted handshake.
- R11: After reset, `reqValid` is 0, `coalesced` is all zero, and every per-pin flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLine | input | NUM_PINS | Interrupt lines, synchronous to clk |
| cfgMask | input | NUM_PINS | Per-pin mask, 1 = masked |
| cfgLevel | input | NUM_PINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfgVector | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| cfgDest | input | NUM_PINS*DEST_W | Per-pin destination, pin i at [i*DEST_W +: DEST_W] |
| cfgDelMode | input | NUM_PINS*MODE_W | Per-pin delivery mode, pin i at [i*MODE_W +: MODE_W] |
| entryWrStb | input | 1 | Table entry for entryWrIdx was rewritten |
| entryWrIdx | input | PIN_W | Pin index of the rewritten entry |
| eoiClrStb | input | 1 | Clear remote-pending of pin eoiClrIdx |
| eoiClrIdx | input | PIN_W | Pin index for the completion clear |
| reqValid | output | 1 | Delivery request valid |
| reqReady | input | 1 | Fabric accepts the request |
| reqPin | output | PIN_W | Pin number of the request |
| reqVector | output | VEC_W | Vector of the request |
| reqDest | output | DEST_W | Destination of the request |
| reqDelMode | output | MODE_W | Delivery mode of the request |
| reqLevel | output | 1 | Request belongs to a level pin |
| coalesced | output | NUM_PINS | One-cycle pulse per pin for a coalesced assertion |

## Verification
The assertions take for granted that the lines and configuration inputs change only between clock edges, are synchronous to `clk`, and that both index inputs are below `NUM_PINS`. They also assume the fabric may hold `reqReady` low for any length of time. The bench drives every input on the falling edge and only ever supplies valid pin indices. It changes a mask at the same moment as the matching rewrite strobe, so the mask value at the loading edge is well defined.

// File: rtl/irq_deliver_pkg.sv
package irq_deliver_pkg;

  // Strobes from the grant control to the request datapath.
  typedef struct packed {
    logic load;  // capture the fields of the selected pin
    logic fire;  // handshake completes this cycle
  } grantStrobes_t;

endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] irqLine,
  input  logic [NUM_PINS-1:0] cfgMask,
  input  logic [NUM_PINS-1:0] cfgLevel,
  input  logic                entryWrStb,
  input  logic [PIN_W-1:0]    entryWrIdx,
  input  logic                eoiClrStb,
  input  logic [PIN_W-1:0]    eoiClrIdx,
  input  logic                fireStb,
  input  logic [PIN_W-1:0]    firePin,
  input  logic                fireLevel,
  output logic [NUM_PINS-1:0] needSvc,
  output logic [NUM_PINS-1:0] coalesced
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic lineQ;
    logic reqBit;
    logic sent;
    logic remotePend;
    logic coalQ;
    logic rise;
    logic fireHit;
    logic clrHit;

    assign rise    = irqLine[g] & ~lineQ;
    assign fireHit = fireStb && (firePin == PIN_W'(g));
    assign clrHit  = (entryWrStb && (entryWrIdx == PIN_W'(g))) ||
                     (eoiClrStb  && (eoiClrIdx  == PIN_W'(g)));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineQ      <= 1'b0;
        reqBit     <= 1'b0;
        sent       <= 1'b0;
        remotePend <= 1'b0;
        coalQ      <= 1'b0;
      end else begin
        lineQ <= irqLine[g];
        // low line withdraws level requests and finished edge requests
        if (!irqLine[g] && (cfgLevel[g] || sent))
          reqBit <= 1'b0;
        else if (rise)
          reqBit <= 1'b1;
        // an acceptance absorbs an assertion seen in the same cycle
        if (fireHit && !fireLevel)
          sent <= 1'b1;
        else if (rise)
          sent <= 1'b0;
        if (fireHit && fireLevel)
          remotePend <= 1'b1;
        else if (clrHit)
          remotePend <= 1'b0;
        coalQ <= rise & (cfgLevel[g] ? remotePend : (reqBit & ~sent));
      end
    end

    assign needSvc[g]   = reqBit & ~cfgMask[g] &
                          (cfgLevel[g] ? ~remotePend : ~sent);
    assign coalesced[g] = coalQ;
  end

endmodule

// File: rtl/irq_grant_ctrl.sv
module irq_grant_ctrl
  import irq_deliver_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] needSvc,
  input  logic                reqReady,
  output logic                reqValid,
  output logic [PIN_W-1:0]    selPin,
  output grantStrobes_t       strobes
);

  logic holdValid;
  logic anyReq;

  assign anyReq = |needSvc;

  // fixed priority: scan downwards so the lowest set bit wins
  always_comb begin
    selPin = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (needSvc[i]) selPin = PIN_W'(i);
    end
  end

  assign strobes.load = !holdValid && anyReq;
  assign strobes.fire = holdValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN)             holdValid <= 1'b0;
    else if (strobes.load) holdValid <= 1'b1;
    else if (strobes.fire) holdValid <= 1'b0;
  end

  assign reqValid = holdValid;

endmodule

// File: rtl/irq_req_datapath.sv
module irq_req_datapath
  import irq_deliver_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  parameter int MODE_W   = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  grantStrobes_t              strobes,
  input  logic [PIN_W-1:0]           selPin,
  input  logic [NUM_PINS*VEC_W-1:0]  cfgVector,
  input  logic [NUM_PINS*DEST_W-1:0] cfgDest,
  input  logic [NUM_PINS*MODE_W-1:0] cfgDelMode,
  input  logic [NUM_PINS-1:0]        cfgLevel,
  output logic [PIN_W-1:0]           reqPin,
  output logic [VEC_W-1:0]           reqVector,
  output logic [DEST_W-1:0]          reqDest,
  output logic [MODE_W-1:0]          reqDelMode,
  output logic                       reqLevel
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPin     <= '0;
      reqVector  <= '0;
      reqDest    <= '0;
      reqDelMode <= '0;
      reqLevel   <= 1'b0;
    end else if (strobes.load) begin
      reqPin     <= selPin;
      reqVector  <= cfgVector[selPin*VEC_W +: VEC_W];
      reqDest    <= cfgDest[selPin*DEST_W +: DEST_W];
      reqDelMode <= cfgDelMode[selPin*MODE_W +: MODE_W];
      reqLevel   <= cfgLevel[selPin];
    end
  end

endmodule

// File: rtl/irq_pin_deliver.sv
module irq_pin_deliver
  import irq_deliver_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  parameter int MODE_W   = 3,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        irqLine,
  input  logic [NUM_PINS-1:0]        cfgMask,
  input  logic [NUM_PINS-1:0]        cfgLevel,
  input  logic [NUM_PINS*VEC_W-1:0]  cfgVector,
  input  logic [NUM_PINS*DEST_W-1:0] cfgDest,
  input  logic [NUM_PINS*MODE_W-1:0] cfgDelMode,
  input  logic                       entryWrStb,
  input  logic [PIN_W-1:0]           entryWrIdx,
  input  logic                       eoiClrStb,
  input  logic [PIN_W-1:0]           eoiClrIdx,
  output logic                       reqValid,
  input  logic                       reqReady,
  output logic [PIN_W-1:0]           reqPin,
  output logic [VEC_W-1:0]           reqVector,
  output logic [DEST_W-1:0]          reqDest,
  output logic [MODE_W-1:0]          reqDelMode,
  output logic                       reqLevel,
  output logic [NUM_PINS-1:0]        coalesced
);

  logic [NUM_PINS-1:0] needSvc;
  logic [PIN_W-1:0]    selPin;
  grantStrobes_t       strobes;

  irq_pin_track #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_track (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .cfgMask(cfgMask),
    .cfgLevel(cfgLevel), .entryWrStb(entryWrStb), .entryWrIdx(entryWrIdx),
    .eoiClrStb(eoiClrStb), .eoiClrIdx(eoiClrIdx), .fireStb(strobes.fire),
    .firePin(reqPin), .fireLevel(reqLevel), .needSvc(needSvc),
    .coalesced(coalesced)
  );

  irq_grant_ctrl #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .needSvc(needSvc), .reqReady(reqReady),
    .reqValid(reqValid), .selPin(selPin), .strobes(strobes)
  );

  irq_req_datapath #(
    .NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .VEC_W(VEC_W),
    .DEST_W(DEST_W), .MODE_W(MODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selPin(selPin),
    .cfgVector(cfgVector), .cfgDest(cfgDest), .cfgDelMode(cfgDelMode),
    .cfgLevel(cfgLevel), .reqPin(reqPin), .reqVector(reqVector),
    .reqDest(reqDest), .reqDelMode(reqDelMode), .reqLevel(reqLevel)
  );

endmodule

// File: rtl/irq_pin_deliver_chk.sv
module irq_pin_deliver_chk #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  parameter int MODE_W   = 3,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] irqLine,
  input logic [NUM_PINS-1:0] cfgMask,
  input logic                reqValid,
  input logic                reqReady,
  input logic [PIN_W-1:0]    reqPin,
  input logic [VEC_W-1:0]    reqVector,
  input logic [DEST_W-1:0]   reqDest,
  input logic [NUM_PINS-1:0] coalesced
);

  logic [NUM_PINS-1:0] maskQ;
  always_ff @(posedge clk) maskQ <= cfgMask;

  p_coal_needs_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    (coalesced & ~$past(irqLine)) == '0);

  p_masked_no_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> !maskQ[reqPin]);

  p_pin_in_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (int'(reqPin) < NUM_PINS));

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=>
      (reqValid && $stable(reqPin) && $stable(reqVector) && $stable(reqDest)));

  p_gap_after_fire_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqValid);

endmodule

bind irq_pin_deliver irq_pin_deliver_chk #(
  .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .MODE_W(MODE_W)
) i_chk (.*);

// File: tb/test_irq_pin_deliver.sv
`timescale 1ns/1ps
module test_irq_pin_deliver;
  localparam int N  = 24;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  irqLine, cfgMask, cfgLevel;
  logic [N*8-1:0] cfgVector, cfgDest;
  logic [N*3-1:0] cfgDelMode;
  logic          entryWrStb, eoiClrStb, reqReady;
  logic [PW-1:0] entryWrIdx, eoiClrIdx;
  logic          reqValid, reqLevel;
  logic [PW-1:0] reqPin;
  logic [7:0]    reqVector, reqDest;
  logic [2:0]    reqDelMode;
  logic [N-1:0]  coalesced;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  irq_pin_deliver i_irq_pin_deliver (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .cfgMask(cfgMask),
    .cfgLevel(cfgLevel), .cfgVector(cfgVector), .cfgDest(cfgDest),
    .cfgDelMode(cfgDelMode), .entryWrStb(entryWrStb), .entryWrIdx(entryWrIdx),
    .eoiClrStb(eoiClrStb), .eoiClrIdx(eoiClrIdx), .reqValid(reqValid),
    .reqReady(reqReady), .reqPin(reqPin), .reqVector(reqVector),
    .reqDest(reqDest), .reqDelMode(reqDelMode), .reqLevel(reqLevel),
    .coalesced(coalesced)
  );

  // row: {lines[54:31], ready[30], expValid[29], expPin[28:24], expCoal[23:0]}
  localparam logic [54:0] TBL [8] = '{
    {24'h000008, 1'b0, 1'b0, 5'd0, 24'h000000},
    {24'h000028, 1'b0, 1'b1, 5'd3, 24'h000000},
    {24'h000020, 1'b0, 1'b1, 5'd3, 24'h000000},
    {24'h000028, 1'b0, 1'b1, 5'd3, 24'h000008},
    {24'h000028, 1'b1, 1'b0, 5'd0, 24'h000000},
    {24'h000028, 1'b1, 1'b1, 5'd5, 24'h000000},
    {24'h000028, 1'b1, 1'b0, 5'd0, 24'h000000},
    {24'h000028, 1'b1, 1'b0, 5'd0, 24'h000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqLine = '0; reqReady = 1'b0;
    entryWrStb = 1'b0; eoiClrStb = 1'b0; entryWrIdx = '0; eoiClrIdx = '0;
    cfgLevel = 24'hFF0000;
    cfgMask  = 24'h0C0000;
    for (int i = 0; i < N; i++) begin
      cfgVector[i*8 +: 8]  = 8'(8'h30 + i);
      cfgDest[i*8 +: 8]    = 8'(i * 3);
      cfgDelMode[i*3 +: 3] = 3'(i % 8);
    end
    @(negedge clk); tick(); tick();
    rstN = 1'b1;
    chk("R11 reset valid", 32'(reqValid), 0);
    chk("R11 reset coalesced", 32'(coalesced), 0);

    // table: edge pins 3 and 5, coalesce, hold, priority, no re-request
    for (int k = 0; k < 8; k++) begin
      irqLine  = TBL[k][54:31];
      reqReady = TBL[k][30];
      tick();
      chk($sformatf("R9/R2 row%0d valid", k), 32'(reqValid), 32'(TBL[k][29]));
      if (TBL[k][29]) chk($sformatf("R8 row%0d pin", k), 32'(reqPin), 32'(TBL[k][28:24]));
      chk($sformatf("R2 row%0d coalesced", k), 32'(coalesced), 32'(TBL[k][23:0]));
    end

    // R5 / R10: re-assertion of a sent edge pin, latency
    irqLine = '0; tick();
    irqLine[3] = 1'b1; tick();
    chk("R10 no request one edge after", 32'(reqValid), 0);
    tick();
    chk("R5 new request after re-assert", 32'(reqValid), 1);
    chk("R5 pin", 32'(reqPin), 3);
    tick();
    chk("R10 gap after accept", 32'(reqValid), 0);
    irqLine = '0; tick();

    // R8: simultaneous pins 9 and 7
    reqReady = 1'b0;
    irqLine[7] = 1'b1; irqLine[9] = 1'b1; tick(); tick();
    chk("R8 first is lowest", 32'(reqPin), 7);
    reqReady = 1'b1; tick(); tick();
    chk("R8 second valid", 32'(reqValid), 1);
    chk("R8 second pin", 32'(reqPin), 9);
    tick(); irqLine = '0; tick();

    // R9 / R6 / R3 / R7: level pin 16
    irqLine[16] = 1'b1; tick(); tick();
    chk("R9 level valid", 32'(reqValid), 1);
    chk("R9 level pin", 32'(reqPin), 16);
    chk("R9 reqLevel", 32'(reqLevel), 1);
    chk("R9 vector", 32'(reqVector), 32'h40);
    chk("R9 dest", 32'(reqDest), 48);
    chk("R9 mode", 32'(reqDelMode), 0);
    tick();
    irqLine[16] = 1'b0; tick();
    irqLine[16] = 1'b1; tick();
    chk("R3 level coalesced", 32'(coalesced), 32'h010000);
    tick(); tick();
    chk("R3 held off by remote pending", 32'(reqValid), 0);
    eoiClrStb = 1'b1; eoiClrIdx = 5'd16; tick();
    eoiClrStb = 1'b0; tick();
    chk("R6 request after completion clear", 32'(reqValid), 1);
    chk("R6 pin", 32'(reqPin), 16);
    tick(); tick();
    chk("R6 held off again", 32'(reqValid), 0);
    entryWrStb = 1'b1; entryWrIdx = 5'd16; tick();
    entryWrStb = 1'b0; tick();
    chk("R7 rewrite reservices level pin", 32'(reqValid), 1);
    chk("R7 pin", 32'(reqPin), 16);
    tick(); irqLine[16] = 1'b0; tick();

    // R1: masked level pulse that ends is withdrawn
    irqLine[18] = 1'b1; tick(); tick();
    irqLine[18] = 1'b0; tick();
    cfgMask[18] = 1'b0; entryWrStb = 1'b1; entryWrIdx = 5'd18; tick();
    entryWrStb = 1'b0; tick();
    chk("R1 withdrawn level not sent", 32'(reqValid), 0);
    tick();
    chk("R1 still idle", 32'(reqValid), 0);

    // R4 / R7: masked held level pin latched, retried on rewrite
    irqLine[19] = 1'b1; tick(); tick(); tick();
    chk("R4 masked pin no request", 32'(reqValid), 0);
    cfgMask[19] = 1'b0; entryWrStb = 1'b1; entryWrIdx = 5'd19; tick();
    entryWrStb = 1'b0;
    chk("R7 unmasked latched pin requested", 32'(reqValid), 1);
    chk("R4 latched pin", 32'(reqPin), 19);
    tick(); irqLine = '0; tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule